// File: doc/BRIEF.md
# Register-Mapped Chunky-to-Planar Converter

This peripheral turns a block of 32 packed 8-bit pixels into eight 32-bit bitplane words. A host stores eight words of pixel data, one after another, at a single register address. It then reads eight words back from that same address. Each word it reads is one bitplane. The conversion is a transpose of a bit matrix: 32 rows of 8 bits become 8 rows of 32 bits.

The block holds the 256 captured bits in internal storage. The transpose is pure wiring over that storage. A write counter and a read counter step through the words. A read issued too early returns zero and sets a sticky error flag, which the host clears with a dedicated input.

Top module: `c2p_engine`

## Requirements
- R1: After reset, `rdata` is 0, `err` is 0 and no batch is held, so a read right after reset counts as an early read.
- R2: Writes that hit address `BASE` fill the eight input words in order. Within an input word, bits [31:24] hold the lowest-numbered of its four pixels and bits [7:0] hold the highest. Word j therefore carries pixels 4j to 4j+3.
- R3: Once eight words are held, read number k (k = 0..7) returns plane k. Bit (31-p) of plane k equals bit k of pixel p, so pixel 0 is the MSB and plane 0 holds every pixel's LSB.
- R4: A read that hits `BASE` updates `rdata` at the clock edge that samples it. The first read may come in the cycle right after the eighth write. `rdata` keeps its value until the next read that hits `BASE`.
- R5: A read that hits `BASE` while fewer than eight words of the current batch are held returns 0 and sets `err`.
- R6: `err` stays set until `err_clr` is asserted. When `err_clr` arrives in the same cycle as a new early read, `err` stays set.
- R7: Any write that hits `BASE` moves the read pointer back to plane 0. A write made while eight words are held starts a new batch, with that word as pixels 0 to 3. Reads are then treated as early until the new batch has eight words.
- R8: A read after plane 7 wraps around to plane 0 of the same batch.
- R9: Accesses to any address other than `BASE` have no effect. When `wr_en` and `rd_en` are both set in the same cycle, only the write takes place and `rdata` does not change.
- R10: Pixel values come back intact. A pixel of value 0xAC reappears when its bit is gathered from planes 7 down to 0, giving 1,0,1,0,1,1,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| addr | input | ADDR_W | Register address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Packed pixel word to store |
| err_clr | input | 1 | Clears the sticky error flag |
| rdata | output | DATA_W | Last plane word read, registered |
| err | output | 1 | Sticky flag for an early read |

## Verification
A write counter that skips or repeats a slot shows up as a plane that is wrong in one group of four bit positions. A slipped read pointer returns a correct plane at the wrong position. Either fault shows on the first read after the batch is complete. A full flag that is wrong either lets an early read return stale planes without `err`, or blocks a valid read with `err`, and both show at the very next read. Every plane of several batches is compared bit for bit against a model built from the pixel values, so a single swapped index is caught within eight reads.

// File: rtl/c2p_pkg.sv
package c2p_pkg;

    // Default geometry: 32 pixels of 8 bits
    localparam int DEF_DATA_W = 32;
    localparam int DEF_PIX_W  = 8;
    localparam int DEF_ADDR_W = 8;

    // Kind of bus access seen at the converter address this cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

endpackage

// File: rtl/c2p_capture.sv
module c2p_capture
    import c2p_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PIX_W  = DEF_PIX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  acc_e                     acc,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W*PIX_W-1:0]  matrix_o,
    output logic                     full_o
);
    // One pixel per output bit, so the input holds PIX_W words
    localparam int WORDS = (DATA_W * PIX_W) / DATA_W;
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] words;
        logic [CNT_W-1:0]             wcnt;
        logic                         full;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (acc == ACC_WRITE) begin
            if (cap_q.full) begin
                // ninth write opens a fresh batch
                cap_d.words[0] = wdata;
                cap_d.wcnt     = ONE;
                cap_d.full     = 1'b0;
            end else begin
                cap_d.words[cap_q.wcnt] = wdata;
                cap_d.wcnt              = cap_q.wcnt + ONE;
                if (cap_q.wcnt == LAST) begin
                    cap_d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // Word 0 sits at the top of the flat matrix, so pixel 0 is the MSB byte
    for (genvar i = 0; i < WORDS; i++) begin : g_flat
        assign matrix_o[(WORDS-1-i)*DATA_W +: DATA_W] = cap_q.words[i];
    end

    assign full_o = cap_q.full;

endmodule

// File: rtl/c2p_transpose.sv
module c2p_transpose #(
    parameter int DATA_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic [DATA_W*PIX_W-1:0] matrix_i,
    output logic [PIX_W*DATA_W-1:0] planes_o
);
    // Pixel p occupies matrix bits [(DATA_W-1-p)*PIX_W +: PIX_W].
    // Plane k sits at planes_o[k*DATA_W +: DATA_W], pixel p at bit DATA_W-1-p.
    for (genvar p = 0; p < DATA_W; p++) begin : g_pix
        for (genvar k = 0; k < PIX_W; k++) begin : g_bit
            assign planes_o[k*DATA_W + (DATA_W-1-p)] = matrix_i[(DATA_W-1-p)*PIX_W + k];
        end
    end

endmodule

// File: rtl/c2p_readout.sv
module c2p_readout
    import c2p_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PIX_W  = DEF_PIX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  acc_e                     acc,
    input  logic                     full_i,
    input  logic                     err_clr,
    input  logic [PIX_W*DATA_W-1:0]  planes_i,
    output logic [DATA_W-1:0]        rdata,
    output logic                     err
);
    localparam int PTR_W = (PIX_W > 1) ? $clog2(PIX_W) : 1;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0]  rptr;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] cur_plane;
    logic              early_rd;

    always_comb begin
        cur_plane = planes_i[rd_q.rptr*DATA_W +: DATA_W];
        early_rd  = (acc == ACC_READ) && !full_i;
    end

    always_comb begin
        rd_d = rd_q;
        if (err_clr) begin
            rd_d.err = 1'b0;
        end
        case (acc)
            ACC_WRITE: rd_d.rptr = '0;
            ACC_READ: begin
                if (full_i) begin
                    rd_d.rdata = cur_plane;
                    rd_d.rptr  = rd_q.rptr + ONE;
                end else begin
                    rd_d.rdata = '0;
                end
            end
            default: ;
        endcase
        if (early_rd) begin
            rd_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rdata;
    assign err   = rd_q.err;

endmodule

// File: rtl/c2p_engine.sv
module c2p_engine
    import c2p_pkg::*;
#(
    parameter int                ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'('h30),
    parameter int                DATA_W = DEF_DATA_W,
    parameter int                PIX_W  = DEF_PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    localparam int MAT_W = DATA_W * PIX_W;

    acc_e             acc;
    logic             batch_full;
    logic [MAT_W-1:0] matrix;
    logic [MAT_W-1:0] planes;

    // A write beats a read in the same cycle
    always_comb begin
        acc = ACC_NONE;
        if (addr == BASE) begin
            if (wr_en) begin
                acc = ACC_WRITE;
            end else if (rd_en) begin
                acc = ACC_READ;
            end
        end
    end

    c2p_capture #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (wdata),
        .matrix_o (matrix),
        .full_o   (batch_full)
    );

    c2p_transpose #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_xpose (
        .matrix_i (matrix),
        .planes_o (planes)
    );

    c2p_readout #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .full_i   (batch_full),
        .err_clr  (err_clr),
        .planes_i (planes),
        .rdata    (rdata),
        .err      (err)
    );

endmodule

// File: rtl/c2p_engine_chk.sv
module c2p_engine_chk #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'('h30),
    parameter int                DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              err_clr,
    input logic [DATA_W-1:0] rdata,
    input logic              err,
    input logic              batch_full
);
    logic rd_go;
    logic wr_go;
    assign wr_go = wr_en && (addr == BASE);
    assign rd_go = rd_en && !wr_en && (addr == BASE);

    AST_EARLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go && !batch_full |=> (rdata == '0) && err);                  // R5
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_clr |=> err);                                        // R6
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !(rd_go && !batch_full) |=> !err);                    // R6
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata));                                      // R4
    AST_NEW_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && batch_full |=> !batch_full);                            // R7
    AST_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        batch_full && !wr_go |=> batch_full);                            // R9

endmodule

bind c2p_engine c2p_engine_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .err_clr    (err_clr),
    .rdata      (rdata),
    .err        (err),
    .batch_full (batch_full)
);

// File: tb/c2p_engine_test.sv
module c2p_engine_test;
    localparam logic [7:0] BASE = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        err_clr = 1'b0;
    logic [31:0] rdata;
    logic        err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] words [8];

    always #10 clk = ~clk;

    c2p_engine #(.ADDR_W(8), .BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .err_clr(err_clr), .rdata(rdata), .err(err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_plane(int k);
        logic [31:0] res = '0;
        for (int p = 0; p < 32; p++) begin
            logic [7:0] px = words[p/4][31-8*(p%4) -: 8];
            res[31-p] = px[k];
        end
        return res;
    endfunction

    // Drive at the falling edge, the access is taken at the next rising edge
    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic load_batch();
        for (int i = 0; i < 8; i++) bus_wr(BASE, words[i]);
    endtask

    task automatic t_reset();
        check("R1 rdata", rdata, 32'h0);
        check("R1 err", {31'h0, err}, 32'h0);
    endtask

    task automatic t_early_and_err();
        logic [31:0] d;
        bus_rd(BASE, d);
        check("R1 R5 early read data", d, 32'h0);
        check("R5 err set", {31'h0, err}, 32'h1);
        @(negedge clk);
        check("R6 err sticky", {31'h0, err}, 32'h1);
        // clear together with a new early read: set wins
        err_clr = 1'b1;
        bus_rd(BASE, d);
        err_clr = 1'b0;
        check("R6 set beats clear", {31'h0, err}, 32'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R6 err cleared", {31'h0, err}, 32'h0);
    endtask

    task automatic t_ramp();
        logic [31:0] d;
        for (int i = 0; i < 8; i++)
            words[i] = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
        load_batch();
        for (int k = 0; k < 8; k++) begin
            bus_rd(BASE, d);   // first read directly after the eighth write
            check($sformatf("R2 R3 R4 ramp plane %0d", k), d, model_plane(k));
        end
        repeat (2) @(negedge clk);
        check("R4 rdata held", rdata, model_plane(7));
        bus_rd(BASE, d);
        check("R8 wrap to plane 0", d, model_plane(0));
        check("R3 no err on valid reads", {31'h0, err}, 32'h0);
    endtask

    task automatic t_pattern_ac();
        logic [31:0] d;
        logic [7:0]  pix0 = '0;
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            words[i] = s;
        end
        words[0][31:24] = 8'hAC;
        load_batch();
        for (int k = 0; k < 8; k++) begin
            bus_rd(BASE, d);
            check($sformatf("R3 mixed plane %0d", k), d, model_plane(k));
            pix0[k] = d[31];
        end
        check("R10 pixel 0 rebuilt", {24'h0, pix0}, 32'hAC);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        // ninth write starts a new batch, reads are early again
        bus_wr(BASE, 32'hFFFF_0000);
        bus_rd(BASE, d);
        check("R7 new batch read blocked", d, 32'h0);
        check("R7 err after ninth write", {31'h0, err}, 32'h1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        words[0] = 32'hFFFF_0000;
        for (int i = 1; i < 8; i++) begin
            words[i] = 32'h0F0F_0F0F ^ (32'h0101_0101 * i);
            bus_wr(BASE, words[i]);
        end
        bus_rd(BASE, d);
        check("R7 new batch plane 0", d, model_plane(0));
        bus_rd(BASE, d);
        bus_rd(BASE, d);
        check("R7 new batch plane 2", d, model_plane(2));
        // reload mid read sequence: pointer returns to plane 0
        for (int i = 0; i < 8; i++) words[i] = ~words[i];
        load_batch();
        bus_rd(BASE, d);
        check("R7 pointer reset by write", d, model_plane(0));
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        bus_wr(BASE + 8'h4, 32'hDEAD_BEEF);
        bus_rd(BASE, d);
        check("R9 foreign write ignored", d, model_plane(1));
        bus_rd(BASE + 8'h4, d);
        check("R9 foreign read keeps rdata", d, model_plane(1));
        bus_rd(BASE, d);
        check("R9 foreign read keeps pointer", d, model_plane(2));
        // simultaneous write and read: a write only, starts new batch
        addr = BASE; wdata = 32'h1111_2222; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 rdata not changed by combined access", rdata, model_plane(2));
        bus_rd(BASE, d);
        check("R9 combined access acted as write", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_early_and_err();
        t_ramp();
        t_pattern_ac();
        t_restart();
        t_ignore();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule